// File: doc/BRIEF.md
# Memory Secure Region Filter

This block sits in front of a memory port and decides, one access at a time, whether the access may proceed. Software sets up eight address windows, each bounded by an inclusive first and last megabyte. A control register chooses which windows are secure. A further bit makes all memory that lies outside every window secure, and a bypass bit switches all checking off. A non-secure access that lands in secure memory is denied. A secure access is always let through.

Configuration arrives over a small register bus. Each 32-bit write carries its own write-enable mask in the upper half, so a single bit can be changed without a read-modify-write. On the access side the caller presents an address, a secure flag and a valid strobe. One clock later the block returns a valid strobe and a permit bit. When reset releases, bypass is on, so nothing is blocked until software has programmed the windows and cleared bypass.

Top module: `mem_sec_filter`

## Requirements
- R1: After reset every window start and end register reads 0, the control register reads 0x0200 (bypass set, all other bits clear), and every access is permitted.
- R2: A register write takes bits 31:16 of the write data as a mask for bits 15:0. A stored bit changes only where its mask bit is 1. Reads always return 0 in bits 31:16.
- R3: Register index n (0..7) holds the first megabyte of window n, index n+8 holds its last megabyte, and index 16 is control. Window fields are 12 bits wide and read 0 above bit 11. Control bits above bit 9 read 0. Writes to indexes 17..31 change nothing, and those indexes read 0.
- R4: An address lies in window n when its megabyte number addr[31:20] is at least the window's start and at most its end, both bounds inclusive. A window whose end is below its start contains no address.
- R5: A non-secure access inside a window whose control bit n (bits 0..7) is 1 is denied when bypass is clear.
- R6: An access with the secure flag set is always permitted.
- R7: With control bit 8 set and bypass clear, a non-secure access that lies in no window is denied. Any window counts for this, whether enabled or not. With bit 8 clear, such an access is permitted.
- R8: With control bit 9 (bypass) set, every access is permitted, whatever the other settings.
- R9: Where windows overlap, a non-secure access is denied if at least one enabled window covers it. An address covered only by disabled windows is permitted.
- R10: The permit result and its valid strobe appear on the clock edge after the access is presented. No result valid appears without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index for write and read |
| reg_wdata | input | 32 | Mask in bits 31:16, data in bits 15:0 |
| reg_rdata | output | 32 | Read value of the register at reg_addr (combinational) |
| acc_valid | input | 1 | Access request strobe |
| acc_addr | input | 32 | Byte address of the access |
| acc_secure | input | 1 | 1 when the access is secure |
| res_valid | output | 1 | Result strobe, one cycle after acc_valid |
| res_permit | output | 1 | 1 when the access is permitted |

## Verification
The assertions assume that acc_secure and acc_addr are stable and meaningful whenever acc_valid is high. They also assume that a register write does not happen in the same cycle as an access whose verdict depends on that register, because the verdict uses the configuration as it stood before that edge. The bench keeps to both rules: it finishes each configuration write before a sweep starts, and it drops acc_valid between sweeps. Each sweep walks every one of the 4096 megabyte numbers with a non-secure flag, and a strided subset of them with a secure flag. The bench varies the low address bits from page to page, which shows that only the megabyte number decides the verdict.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  // Register payload and mask halves are both this wide.
  localparam int unsigned REG_DW = 16;

  // Masked update: bits with mask 1 take the new value, others keep the old.
  function automatic logic [REG_DW-1:0] merge_masked(
    input logic [REG_DW-1:0] old_val,
    input logic [2*REG_DW-1:0] wr_word
  );
    logic [REG_DW-1:0] msk;
    logic [REG_DW-1:0] dat;
    msk = wr_word[2*REG_DW-1:REG_DW];
    dat = wr_word[REG_DW-1:0];
    return (old_val & ~msk) | (dat & msk);
  endfunction

endpackage

// File: rtl/sfp_regfile.sv
module sfp_regfile #(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned PAGE_W  = 12,
  parameter int unsigned IDX_W   = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_wr,
  input  logic [IDX_W-1:0]                 reg_addr,
  input  logic [2*sfp_pkg::REG_DW-1:0]     reg_wdata,
  output logic [2*sfp_pkg::REG_DW-1:0]     reg_rdata,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]   win_lo,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]   win_hi,
  output logic [NUM_WIN-1:0]               win_en,
  output logic                             rest_sec,
  output logic                             bypass
);
  import sfp_pkg::*;

  localparam int unsigned CTRL_W   = NUM_WIN + 2;
  localparam int unsigned CTRL_IDX = 2 * NUM_WIN;
  localparam int unsigned REST_BIT = NUM_WIN;
  localparam int unsigned BYP_BIT  = NUM_WIN + 1;
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1) << BYP_BIT;

  logic [NUM_WIN-1:0][PAGE_W-1:0] lo_q;
  logic [NUM_WIN-1:0][PAGE_W-1:0] hi_q;
  logic [CTRL_W-1:0]              ctrl_q;

  // Named decode events, used by the assertions below.
  logic wr_ctrl;
  logic wr_outside;
  assign wr_ctrl    = reg_wr && (reg_addr == IDX_W'(CTRL_IDX));
  assign wr_outside = reg_wr && (reg_addr > IDX_W'(CTRL_IDX));

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win_regs
    logic wr_lo;
    logic wr_hi;
    assign wr_lo = reg_wr && (reg_addr == IDX_W'(gi));
    assign wr_hi = reg_wr && (reg_addr == IDX_W'(gi + NUM_WIN));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[gi] <= '0;
      end else if (wr_lo) begin
        lo_q[gi] <= PAGE_W'(merge_masked(REG_DW'(lo_q[gi]), reg_wdata));
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q[gi] <= '0;
      end else if (wr_hi) begin
        hi_q[gi] <= PAGE_W'(merge_masked(REG_DW'(hi_q[gi]), reg_wdata));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_ctrl) begin
      ctrl_q <= CTRL_W'(merge_masked(REG_DW'(ctrl_q), reg_wdata));
    end
  end

  // Read path: upper half always zero.
  logic [REG_DW-1:0] rd_lo;
  always_comb begin
    rd_lo = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (reg_addr == IDX_W'(i))           rd_lo = REG_DW'(lo_q[i]);
      if (reg_addr == IDX_W'(i + NUM_WIN)) rd_lo = REG_DW'(hi_q[i]);
    end
    if (reg_addr == IDX_W'(CTRL_IDX)) rd_lo = REG_DW'(ctrl_q);
  end
  assign reg_rdata = {{REG_DW{1'b0}}, rd_lo};

  assign win_lo   = lo_q;
  assign win_hi   = hi_q;
  assign win_en   = ctrl_q[NUM_WIN-1:0];
  assign rest_sec = ctrl_q[REST_BIT];
  assign bypass   = ctrl_q[BYP_BIT];

  // A control write with an all-zero mask leaves control untouched.
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && (reg_wdata[REG_DW +: CTRL_W] == '0)) |=> $stable(ctrl_q));

  // Writes beyond the control index change no stored state.
  assert_idx_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_outside |=> ($stable(ctrl_q) && $stable(lo_q) && $stable(hi_q)));

  // Read data never carries anything in the mask half.
  assert_rd_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[2*REG_DW-1:REG_DW] == '0);

endmodule

// File: rtl/sfp_window_match.sv
module sfp_window_match #(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned PAGE_W  = 12
) (
  input  logic [PAGE_W-1:0]                page,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0]   win_lo,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0]   win_hi,
  output logic [NUM_WIN-1:0]               hit
);

  // Inclusive range test; an inverted range has no page satisfying both.
  function automatic logic page_in_range(
    input logic [PAGE_W-1:0] p,
    input logic [PAGE_W-1:0] lo,
    input logic [PAGE_W-1:0] hi
  );
    return (p >= lo) && (p <= hi);
  endfunction

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_cmp
    assign hit[gi] = page_in_range(page, win_lo[gi], win_hi[gi]);
  end

endmodule

// File: rtl/sfp_decide.sv
module sfp_decide #(
  parameter int unsigned NUM_WIN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_secure,
  input  logic [NUM_WIN-1:0] hit,
  input  logic [NUM_WIN-1:0] win_en,
  input  logic               rest_sec,
  input  logic               bypass,
  output logic               res_valid,
  output logic               res_permit
);

  // Named internal events.
  logic [NUM_WIN-1:0] sec_cover;
  logic               in_secure_win;
  logic               in_no_win;
  logic               rest_block;
  logic               deny_now;

  assign sec_cover     = hit & win_en;
  assign in_secure_win = |sec_cover;
  assign in_no_win     = ~|hit;
  assign rest_block    = in_no_win && rest_sec;
  assign deny_now      = !bypass && !acc_secure && (in_secure_win || rest_block);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_permit <= 1'b1;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_permit <= !deny_now;
      end
    end
  end

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !res_valid);

  assert_secure_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_secure) |=> res_permit);

  assert_bypass_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && bypass) |=> res_permit);

  assert_win_deny_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_secure && !bypass && in_secure_win) |=> !res_permit);

  assert_rest_deny_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_secure && !bypass && rest_sec && in_no_win) |=> !res_permit);

  assert_overlap_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_secure && !bypass && ($countones(sec_cover) >= 2))
      |=> !res_permit);

endmodule

// File: rtl/mem_sec_filter.sv
module mem_sec_filter #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAIN_LG2 = 20,
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned IDX_W     = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [IDX_W-1:0]    reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                acc_valid,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic                acc_secure,
  output logic                res_valid,
  output logic                res_permit
);

  localparam int unsigned PAGE_W = ADDR_W - GRAIN_LG2;

  logic [NUM_WIN-1:0][PAGE_W-1:0] win_lo;
  logic [NUM_WIN-1:0][PAGE_W-1:0] win_hi;
  logic [NUM_WIN-1:0]             win_en;
  logic                           rest_sec;
  logic                           bypass;
  logic [NUM_WIN-1:0]             hit;
  logic [PAGE_W-1:0]              acc_page;
  logic                           unused_offset;

  assign acc_page      = acc_addr[ADDR_W-1:GRAIN_LG2];
  assign unused_offset = ^acc_addr[GRAIN_LG2-1:0];

  sfp_regfile #(
    .NUM_WIN (NUM_WIN),
    .PAGE_W  (PAGE_W),
    .IDX_W   (IDX_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .win_lo    (win_lo),
    .win_hi    (win_hi),
    .win_en    (win_en),
    .rest_sec  (rest_sec),
    .bypass    (bypass)
  );

  sfp_window_match #(
    .NUM_WIN (NUM_WIN),
    .PAGE_W  (PAGE_W)
  ) u_match (
    .page   (acc_page),
    .win_lo (win_lo),
    .win_hi (win_hi),
    .hit    (hit)
  );

  sfp_decide #(
    .NUM_WIN (NUM_WIN)
  ) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_secure (acc_secure),
    .hit        (hit),
    .win_en     (win_en),
    .rest_sec   (rest_sec),
    .bypass     (bypass),
    .res_valid  (res_valid),
    .res_permit (res_permit)
  );

  // An inverted window never reports a hit, whatever the page.
  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_chk
    assert_inverted_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hi[gi] < win_lo[gi]) |-> !hit[gi]);
  end

endmodule

// File: tb/mem_sec_filter_bench.sv
`timescale 1ns/1ps
module mem_sec_filter_bench;

  localparam int NW = 8;
  localparam int PW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_secure = 1'b0;
  logic        res_valid;
  logic        res_permit;

  always #4 clk = ~clk;

  mem_sec_filter u_mem_sec_filter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_secure(acc_secure), .res_valid(res_valid),
    .res_permit(res_permit)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Bench-side register model.
  int m_lo [NW];
  int m_hi [NW];
  int m_ctrl;

  // Pending access awaiting its result.
  bit    pend = 0;
  bit    pend_exp;
  string pend_tag;
  int    pend_addr;

  function automatic bit covers(int w, int pg);
    return (pg >= m_lo[w]) && (pg <= m_hi[w]);
  endfunction

  function automatic int n_enabled_cover(int pg);
    int c = 0;
    for (int w = 0; w < NW; w++)
      if (covers(w, pg) && m_ctrl[w]) c++;
    return c;
  endfunction

  function automatic bit any_cover(int pg);
    for (int w = 0; w < NW; w++)
      if (covers(w, pg)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_permit(int addr, bit sec);
    int pg = (addr >> 20) & 32'hFFF;
    if (sec) return 1'b1;
    if (m_ctrl[9]) return 1'b1;
    if (n_enabled_cover(pg) > 0) return 1'b0;
    if (!any_cover(pg) && m_ctrl[8]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string rule_tag(int addr, bit sec);
    int pg = (addr >> 20) & 32'hFFF;
    if (sec) return "R6";
    if (m_ctrl[9]) return "R8";
    if (n_enabled_cover(pg) > 1) return "R9";
    if (n_enabled_cover(pg) == 1) return "R5";
    if (!any_cover(pg)) return "R7";
    return "R4";
  endfunction

  task automatic check(bit cond, string tag, int act, int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(int idx, int data, int mask);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = 5'(idx);
    reg_wdata = {16'(mask), 16'(data)};
    @(negedge clk);
    reg_wr = 1'b0;
    if (idx < NW)
      m_lo[idx] = ((m_lo[idx] & ~mask) | (data & mask)) & 32'hFFF;
    else if (idx < 2*NW)
      m_hi[idx-NW] = ((m_hi[idx-NW] & ~mask) | (data & mask)) & 32'hFFF;
    else if (idx == 2*NW)
      m_ctrl = ((m_ctrl & ~mask) | (data & mask)) & 32'h3FF;
  endtask

  task automatic rchk(int idx, int exp, string tag);
    @(negedge clk);
    reg_addr = 5'(idx);
    #1;
    check(reg_rdata == 32'(exp), tag, reg_rdata, exp);
  endtask

  task automatic check_pending();
    if (pend) begin
      check(res_valid == 1'b1, "R10", res_valid, 1);
      check(res_permit == pend_exp, pend_tag, res_permit, pend_exp);
    end
  endtask

  task automatic access(int addr, bit sec);
    @(negedge clk);
    check_pending();
    acc_valid  = 1'b1;
    acc_addr   = 32'(addr);
    acc_secure = sec;
    pend       = 1'b1;
    pend_exp   = exp_permit(addr, sec);
    pend_tag   = rule_tag(addr, sec);
    pend_addr  = addr;
  endtask

  task automatic flush();
    @(negedge clk);
    check_pending();
    acc_valid = 1'b0;
    pend      = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0, "R10", res_valid, 0);
  endtask

  // Full page sweep non-secure, strided secure; low bits vary per page.
  task automatic sweep();
    for (int pg = 0; pg < 4096; pg++)
      access((pg << 20) | ((pg * 7919) & 32'hFFFFF), 1'b0);
    for (int pg = 0; pg < 4096; pg += 37)
      access((pg << 20) | ((pg * 131) & 32'hFFFFF), 1'b1);
    flush();
  endtask

  initial begin
    repeat (200000 - 10) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) begin m_lo[w] = 0; m_hi[w] = 0; end
    m_ctrl = 32'h200;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of all registers
    for (int i = 0; i < 2*NW; i++) rchk(i, 0, "R1");
    rchk(16, 32'h200, "R1");
    // R1: everything permitted after reset (bypass)
    sweep();

    // R2: zero mask changes nothing
    wreg(16, 32'hFFFF, 32'h0000);
    rchk(16, 32'h200, "R2");
    // R2: only masked bit changes; mask bits read back as 0
    wreg(3, 32'hFFFF, 32'h0005);
    rchk(3, 32'h005, "R2");
    // R3: window fields are 12 bits wide
    wreg(11, 32'hFFFF, 32'hFFFF);
    rchk(11, 32'hFFF, "R3");
    // R3: control bits above 9 read 0
    wreg(16, 32'hFC00, 32'hFC00);
    rchk(16, 32'h200, "R3");
    // R3: indexes beyond control ignore writes and read 0
    wreg(17, 32'hFFFF, 32'hFFFF);
    wreg(31, 32'hFFFF, 32'hFFFF);
    rchk(17, 0, "R3");
    rchk(31, 0, "R3");
    rchk(16, 32'h200, "R3");
    rchk(0, 0, "R3");

    // Window layout
    wreg(0, 0, 32'hFFFF);     wreg(8, 0, 32'hFFFF);       // [0,0]
    wreg(1, 16, 32'hFFFF);    wreg(9, 47, 32'hFFFF);      // [16,47]
    wreg(2, 40, 32'hFFFF);    wreg(10, 63, 32'hFFFF);     // [40,63] overlaps 1
    wreg(3, 100, 32'hFFFF);   wreg(11, 99, 32'hFFFF);     // inverted
    wreg(4, 4095, 32'hFFFF);  wreg(12, 4095, 32'hFFFF);   // top page
    wreg(5, 200, 32'hFFFF);   wreg(13, 300, 32'hFFFF);    // disabled
    wreg(6, 290, 32'hFFFF);   wreg(14, 310, 32'hFFFF);    // overlaps 5
    wreg(7, 1000, 32'hFFFF);  wreg(15, 1000, 32'hFFFF);   // disabled
    rchk(9, 47, "R3");
    rchk(12, 4095, "R3");

    // R5/R9/R4: enable 0..4 and 6, bypass off, outside not secure
    wreg(16, 32'h005F, 32'hFFFF);
    rchk(16, 32'h05F, "R2");
    sweep();

    // R7: memory outside all windows made secure
    wreg(16, 32'h0100, 32'h0100);
    sweep();

    // R9: disable window 2, overlap remains guarded only by window 1
    wreg(16, 32'h0000, 32'h0004);
    sweep();

    // R8: bypass overrides everything
    wreg(16, 32'h0200, 32'h0200);
    sweep();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule